// File: doc/BRIEF.md
# Task-Switch Segment Register Validator

This block checks one segment register load made while the processor switches hardware tasks. It receives the kind of register being loaded (local descriptor table register, code, stack or data), the 16-bit selector, the current privilege level and a flag that says whether the switch came from an external event. It also receives the limits of the global and local descriptor tables and a flag that says whether the local table can be used. Checks that need only the selector are finished in one cycle. Otherwise the block issues one read of the 8-byte descriptor and waits for the data or a page-fault reply.

The result is one of three outcomes. The first is a decoded base, limit and access word. The second is a fault with an exception vector and a 16-bit error code. The third is a page-fault passthrough. Table walking, address translation and memory sit outside the block. It sees only a request/response handshake that carries the byte offset of the descriptor within its table and a flag that picks the table.

The kind code is 0 for the local descriptor table register, 1 for code, 2 for stack and 3 for data (DS/ES/FS/GS). The fault vectors used are 10 (invalid task state segment), 11 (segment not present) and 12 (stack fault).

Top module: `tsk_seg_validator`

## Requirements
- R1: After reset, `done_o`, `rd_req_o`, `busy_o`, `ok_o`, `fault_o` and `pf_o` are all low.
- R2: For kind 0, a selector with bit 2 set gives a fault with vector 10, and no read is made.
- R3: Selector bit 2 picks the local table and bit 2 clear picks the global table. The limit check fails when (selector | 7) is greater than the chosen table's limit. A local-table selector also fails when `ldt_ok_i` is low. Either failure gives vector 10, and no read is made.
- R4: A selector whose bits 15:3 are all zero gives vector 10 for kinds 1 and 2. For kinds 0 and 3 it gives `ok_o` with base 0, limit 0 and access 0x10000, and no read is made. Both results come on the cycle after `start_i`.
- R5: For any other selector, `rd_req_o` rises on the cycle after `start_i`, with `rd_off_o` = selector & 0xFFF8 and `rd_ldt_o` = selector bit 2. It stays high and stable until `rd_valid_i` or `rd_pf_i` is sampled. It then falls, and `done_o` pulses on the same cycle.
- R6: The descriptor holds limit[15:0] in bits 15:0, base[23:0] in bits 39:16, a 5-bit type in bits 44:40, DPL in bits 46:45, present in bit 47, limit[19:16] in bits 51:48, AVL in bit 52, L in bit 53, D/B in bit 54, G in bit 55 and base[31:24] in bits 63:56. The accepted types are: code needs (type & 0x18) == 0x18; stack needs (type & 0x1A) == 0x12; data needs (type & 0x18) == 0x10 or (type & 0x1A) == 0x1A; the local table needs type 0x02. A type that does not match gives vector 10.
- R7: A descriptor that is not present gives vector 10 for kind 0, vector 12 for kind 2 and vector 11 for kinds 1 and 3.
- R8: A stack load faults with vector 10 unless RPL (selector bits 1:0) == CPL and DPL == CPL.
- R9: A code load whose type bit 2 is set (conforming) faults with vector 10 when CPL < DPL. When type bit 2 is clear, it faults when CPL != DPL.
- R10: A data load whose descriptor is a conforming code type passes the privilege check. Any other data load faults with vector 10 when RPL > DPL or CPL > DPL.
- R11: The fault error code is the selector with bits 1:0 cleared and bit 0 then set to `ext_i`. Bits 15:2 are unchanged.
- R12: On success the limit is (raw 20-bit limit << 12) | 0xFFF when G is set, and the raw limit when G is clear. The access word is type in bits 4:0, DPL in bits 6:5, P in bit 7, AVL in bit 12, L in bit 13, D/B in bit 14 and G in bit 15.
- R13: Each `done_o` pulse carries exactly one of `ok_o`, `fault_o` and `pf_o`. A sampled `rd_pf_i` ends the check with `pf_o` set, and `rd_pf_i` takes priority over `rd_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one check; ignored while busy |
| kind_i | input | 2 | Register kind code |
| sel_i | input | 16 | Selector to load |
| cpl_i | input | 2 | Current privilege level |
| ext_i | input | 1 | Switch caused by an external event |
| gdt_limit_i | input | 32 | Global table limit |
| ldt_limit_i | input | 32 | Local table limit |
| ldt_ok_i | input | 1 | Local table usable and present |
| rd_req_o | output | 1 | Descriptor read request |
| rd_off_o | output | 16 | Descriptor byte offset in its table |
| rd_ldt_o | output | 1 | Read targets the local table |
| rd_valid_i | input | 1 | Read data valid |
| rd_pf_i | input | 1 | Read ended in a page fault |
| rd_data_i | input | 64 | Descriptor data |
| busy_o | output | 1 | Waiting for a read reply |
| done_o | output | 1 | One-cycle result strobe |
| ok_o | output | 1 | Segment accepted |
| fault_o | output | 1 | Exception raised |
| pf_o | output | 1 | Page fault passed through |
| vec_o | output | 8 | Exception vector |
| err_o | output | 16 | Exception error code |
| base_o | output | 32 | Decoded base |
| limit_o | output | 32 | Decoded limit |
| access_o | output | 17 | Decoded access word |

## Verification
A kind code latched wrongly, or a privilege comparison off by one, shows up at the ports on the very next `done_o` pulse as the wrong vector or a wrong acceptance. Each case therefore runs with a known kind, CPL and RPL, and the bench compares the result at once. A state machine that leaves the wait state too early or too late shows as `rd_req_o` falling before a reply, or as a missing or late `done_o` strobe. This is visible within one cycle of the reply. The bench holds the reply back for several cycles to expose it.

// File: rtl/tsv_pkg.sv
package tsv_pkg;
  typedef enum logic [1:0] {
    KIND_LDT   = 2'd0,
    KIND_CODE  = 2'd1,
    KIND_STACK = 2'd2,
    KIND_DATA  = 2'd3
  } seg_kind_e;

  localparam logic [7:0] VEC_BADTSS  = 8'd10;
  localparam logic [7:0] VEC_ABSENT  = 8'd11;
  localparam logic [7:0] VEC_STACKF  = 8'd12;
  localparam int         ACC_W       = 17;
  localparam logic [ACC_W-1:0] ACC_UNUSABLE = 17'h10000;
  localparam logic [4:0] TYPE_LDT_SYS = 5'h02;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] lim_raw;
    logic [4:0]  typ;
    logic [1:0]  dpl;
    logic        pres;
    logic        avl;
    logic        lmode;
    logic        db;
    logic        gran;
  } desc_fields_t;

  function automatic logic [15:0] make_errcode(input logic [15:0] sel, input logic ext);
    return {sel[15:2], 1'b0, ext};
  endfunction
endpackage

// File: rtl/tsv_sel_check.sv
module tsv_sel_check
  import tsv_pkg::*;
#(
  parameter int LIM_W = 32
) (
  input  seg_kind_e        kind,
  input  logic [15:0]      sel,
  input  logic [LIM_W-1:0] gdt_limit,
  input  logic [LIM_W-1:0] ldt_limit,
  input  logic             ldt_ok,
  output logic             pre_fault,
  output logic             pre_null
);
  localparam int PAD_W = LIM_W - 16;

  logic [LIM_W-1:0] sel_top;
  logic             use_ldt;
  logic             lim_bad;
  logic             idx_zero;
  logic             bad_ldtr_ti;

  assign sel_top     = {{PAD_W{1'b0}}, (sel | 16'h0007)};
  assign use_ldt     = sel[2];
  assign bad_ldtr_ti = (kind == KIND_LDT) && use_ldt;
  assign idx_zero    = (sel[15:3] == 13'd0);

  always_comb begin
    if (use_ldt) lim_bad = !ldt_ok || (sel_top > ldt_limit);
    else         lim_bad = (sel_top > gdt_limit);
  end

  always_comb begin
    pre_fault = 1'b0;
    pre_null  = 1'b0;
    if (bad_ldtr_ti || lim_bad) begin
      pre_fault = 1'b1;
    end else if (idx_zero) begin
      if (kind == KIND_CODE || kind == KIND_STACK) pre_fault = 1'b1;
      else                                         pre_null  = 1'b1;
    end
  end
endmodule

// File: rtl/tsv_desc_check.sv
module tsv_desc_check
  import tsv_pkg::*;
(
  input  seg_kind_e         kind,
  input  logic [1:0]        rpl,
  input  logic [1:0]        cpl,
  input  logic [63:0]       raw,
  output logic              dc_fault,
  output logic [7:0]        dc_vec,
  output logic [31:0]       dc_base,
  output logic [31:0]       dc_limit,
  output logic [ACC_W-1:0]  dc_access
);
  desc_fields_t f;
  logic is_code, is_stack, is_data, is_ldt, type_ok;
  logic conf, priv_bad;

  always_comb begin
    f.base    = {raw[63:56], raw[39:16]};
    f.lim_raw = {raw[51:48], raw[15:0]};
    f.typ     = raw[44:40];
    f.dpl     = raw[46:45];
    f.pres    = raw[47];
    f.avl     = raw[52];
    f.lmode   = raw[53];
    f.db      = raw[54];
    f.gran    = raw[55];
  end

  assign is_code  = (f.typ & 5'h18) == 5'h18;
  assign is_stack = (f.typ & 5'h1A) == 5'h12;
  assign is_data  = ((f.typ & 5'h18) == 5'h10) || ((f.typ & 5'h1A) == 5'h1A);
  assign is_ldt   = (f.typ == TYPE_LDT_SYS);
  assign conf     = f.typ[2];

  always_comb begin
    case (kind)
      KIND_LDT:   type_ok = is_ldt;
      KIND_CODE:  type_ok = is_code;
      KIND_STACK: type_ok = is_stack;
      default:    type_ok = is_data;
    endcase
  end

  always_comb begin
    case (kind)
      KIND_STACK: priv_bad = (rpl != cpl) || (f.dpl != cpl);
      KIND_CODE:  priv_bad = conf ? (cpl < f.dpl) : (cpl != f.dpl);
      KIND_DATA:  priv_bad = !(is_code && conf) && ((rpl > f.dpl) || (cpl > f.dpl));
      default:    priv_bad = 1'b0;
    endcase
  end

  always_comb begin
    dc_fault = 1'b1;
    dc_vec   = VEC_BADTSS;
    if (!type_ok) begin
      dc_vec = VEC_BADTSS;
    end else if (!f.pres) begin
      case (kind)
        KIND_LDT:   dc_vec = VEC_BADTSS;
        KIND_STACK: dc_vec = VEC_STACKF;
        default:    dc_vec = VEC_ABSENT;
      endcase
    end else if (priv_bad) begin
      dc_vec = VEC_BADTSS;
    end else begin
      dc_fault = 1'b0;
    end
  end

  assign dc_base   = f.base;
  assign dc_limit  = f.gran ? {f.lim_raw, 12'hFFF} : {12'd0, f.lim_raw};
  assign dc_access = {1'b0, f.gran, f.db, f.lmode, f.avl, 4'd0, f.pres, f.dpl, f.typ};
endmodule

// File: rtl/tsk_seg_validator.sv
module tsk_seg_validator
  import tsv_pkg::*;
#(
  parameter int LIM_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       kind_i,
  input  logic [15:0]      sel_i,
  input  logic [1:0]       cpl_i,
  input  logic             ext_i,
  input  logic [LIM_W-1:0] gdt_limit_i,
  input  logic [LIM_W-1:0] ldt_limit_i,
  input  logic             ldt_ok_i,
  output logic             rd_req_o,
  output logic [15:0]      rd_off_o,
  output logic             rd_ldt_o,
  input  logic             rd_valid_i,
  input  logic             rd_pf_i,
  input  logic [63:0]      rd_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ok_o,
  output logic             fault_o,
  output logic             pf_o,
  output logic [7:0]       vec_o,
  output logic [15:0]      err_o,
  output logic [31:0]      base_o,
  output logic [31:0]      limit_o,
  output logic [16:0]      access_o
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e         state;
  seg_kind_e   kind_q;
  logic [15:0] sel_q;
  logic [1:0]  cpl_q;
  logic        ext_q;

  logic pre_fault, pre_null;
  logic dc_fault;
  logic [7:0]  dc_vec;
  logic [31:0] dc_base, dc_limit;
  logic [ACC_W-1:0] dc_access;

  tsv_sel_check #(.LIM_W(LIM_W)) u_sel (
    .kind(seg_kind_e'(kind_i)), .sel(sel_i),
    .gdt_limit(gdt_limit_i), .ldt_limit(ldt_limit_i), .ldt_ok(ldt_ok_i),
    .pre_fault(pre_fault), .pre_null(pre_null)
  );

  tsv_desc_check u_desc (
    .kind(kind_q), .rpl(sel_q[1:0]), .cpl(cpl_q), .raw(rd_data_i),
    .dc_fault(dc_fault), .dc_vec(dc_vec), .dc_base(dc_base),
    .dc_limit(dc_limit), .dc_access(dc_access)
  );

  assign busy_o = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      kind_q   <= KIND_LDT;
      sel_q    <= '0;
      cpl_q    <= '0;
      ext_q    <= 1'b0;
      rd_req_o <= 1'b0;
      rd_off_o <= '0;
      rd_ldt_o <= 1'b0;
      done_o   <= 1'b0;
      ok_o     <= 1'b0;
      fault_o  <= 1'b0;
      pf_o     <= 1'b0;
      vec_o    <= '0;
      err_o    <= '0;
      base_o   <= '0;
      limit_o  <= '0;
      access_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            kind_q <= seg_kind_e'(kind_i);
            sel_q  <= sel_i;
            cpl_q  <= cpl_i;
            ext_q  <= ext_i;
            if (pre_fault) begin
              done_o  <= 1'b1;
              ok_o    <= 1'b0;
              fault_o <= 1'b1;
              pf_o    <= 1'b0;
              vec_o   <= VEC_BADTSS;
              err_o   <= make_errcode(sel_i, ext_i);
            end else if (pre_null) begin
              done_o   <= 1'b1;
              ok_o     <= 1'b1;
              fault_o  <= 1'b0;
              pf_o     <= 1'b0;
              base_o   <= '0;
              limit_o  <= '0;
              access_o <= ACC_UNUSABLE;
            end else begin
              state    <= ST_WAIT;
              rd_req_o <= 1'b1;
              rd_off_o <= sel_i & 16'hFFF8;
              rd_ldt_o <= sel_i[2];
            end
          end
        end
        ST_WAIT: begin
          if (rd_pf_i) begin
            state    <= ST_IDLE;
            rd_req_o <= 1'b0;
            done_o   <= 1'b1;
            ok_o     <= 1'b0;
            fault_o  <= 1'b0;
            pf_o     <= 1'b1;
          end else if (rd_valid_i) begin
            state    <= ST_IDLE;
            rd_req_o <= 1'b0;
            done_o   <= 1'b1;
            pf_o     <= 1'b0;
            if (dc_fault) begin
              ok_o    <= 1'b0;
              fault_o <= 1'b1;
              vec_o   <= dc_vec;
              err_o   <= make_errcode(sel_q, ext_q);
            end else begin
              ok_o     <= 1'b1;
              fault_o  <= 1'b0;
              base_o   <= dc_base;
              limit_o  <= dc_limit;
              access_o <= dc_access;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tsv_checker.sv
module tsv_checker (
  input logic        clk,
  input logic        rst,
  input logic        rd_req_o,
  input logic [15:0] rd_off_o,
  input logic        rd_valid_i,
  input logic        rd_pf_i,
  input logic        done_o,
  input logic        ok_o,
  input logic        fault_o,
  input logic        pf_o,
  input logic [7:0]  vec_o,
  input logic [15:0] err_o,
  input logic [31:0] base_o,
  input logic [31:0] limit_o,
  input logic [16:0] access_o
);
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i && !rd_pf_i) |=> (rd_req_o && $stable(rd_off_o)));

  assert_reply_ends_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && (rd_valid_i || rd_pf_i)) |=> (done_o && !rd_req_o));

  assert_one_outcome_R13: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($countones({ok_o, fault_o, pf_o}) == 1));

  assert_errcode_bit1_R11: assert property (@(posedge clk) disable iff (rst)
    (done_o && fault_o) |-> !err_o[1]);

  assert_null_result_R4: assert property (@(posedge clk) disable iff (rst)
    (done_o && ok_o && access_o[16]) |-> (base_o == 32'd0 && limit_o == 32'd0 && access_o[15:0] == 16'd0));

  assert_vec_range_R7: assert property (@(posedge clk) disable iff (rst)
    (done_o && fault_o) |-> (vec_o >= 8'd10 && vec_o <= 8'd12));

  assert_no_strobe_without_reply_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i && !rd_pf_i) |=> !done_o);
endmodule

bind tsk_seg_validator tsv_checker chk_i (
  .clk(clk), .rst(rst), .rd_req_o(rd_req_o), .rd_off_o(rd_off_o),
  .rd_valid_i(rd_valid_i), .rd_pf_i(rd_pf_i), .done_o(done_o),
  .ok_o(ok_o), .fault_o(fault_o), .pf_o(pf_o), .vec_o(vec_o),
  .err_o(err_o), .base_o(base_o), .limit_o(limit_o), .access_o(access_o)
);

// File: tb/tsk_seg_validator_tb_top.sv
module tsk_seg_validator_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        start_i = 0, ext_i = 0, ldt_ok_i = 1, rd_valid_i = 0, rd_pf_i = 0;
  logic [1:0]  kind_i = 0, cpl_i = 0;
  logic [15:0] sel_i = 0;
  logic [31:0] gdt_limit_i = 32'h00FF, ldt_limit_i = 32'h007F;
  logic [63:0] rd_data_i = 0;
  logic        rd_req_o, rd_ldt_o, busy_o, done_o, ok_o, fault_o, pf_o;
  logic [15:0] rd_off_o, err_o;
  logic [7:0]  vec_o;
  logic [31:0] base_o, limit_o;
  logic [16:0] access_o;

  tsk_seg_validator dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .kind_i(kind_i), .sel_i(sel_i),
    .cpl_i(cpl_i), .ext_i(ext_i), .gdt_limit_i(gdt_limit_i), .ldt_limit_i(ldt_limit_i),
    .ldt_ok_i(ldt_ok_i), .rd_req_o(rd_req_o), .rd_off_o(rd_off_o), .rd_ldt_o(rd_ldt_o),
    .rd_valid_i(rd_valid_i), .rd_pf_i(rd_pf_i), .rd_data_i(rd_data_i), .busy_o(busy_o),
    .done_o(done_o), .ok_o(ok_o), .fault_o(fault_o), .pf_o(pf_o), .vec_o(vec_o),
    .err_o(err_o), .base_o(base_o), .limit_o(limit_o), .access_o(access_o)
  );

  typedef struct {
    string       tag;
    logic        rd, ok, fault, pf;
    logic [7:0]  vec;
    logic [15:0] err;
    logic [31:0] base, limit;
    logic [16:0] acc;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  task automatic chk(input bit good, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [63:0] mkdesc(input logic [31:0] b, input logic [19:0] l, input logic [4:0] t,
                                         input logic [1:0] dpl, input logic p, input logic g);
    return {b[31:24], g, 1'b1, 1'b0, 1'b0, l[19:16], p, dpl, t, b[23:0], l[15:0]};
  endfunction

  function automatic exp_t model(input string tag, input logic [1:0] k, input logic [15:0] s,
                                 input logic [1:0] c, input logic x, input logic [63:0] d, input logic pfr);
    exp_t e;
    logic [4:0] t; logic [1:0] dpl, rpl; logic tok, bad; int top;
    e.tag = tag; e.rd = 0; e.ok = 0; e.fault = 0; e.pf = 0; e.vec = 0;
    e.err = {s[15:2], 1'b0, x}; e.base = 0; e.limit = 0; e.acc = 0;
    top = int'(s | 16'h7);
    if (k == 2'd0 && s[2]) begin e.fault = 1; e.vec = 10; end
    else if (s[2] ? (!ldt_ok_i || top > int'(ldt_limit_i)) : (top > int'(gdt_limit_i))) begin e.fault = 1; e.vec = 10; end
    else if (s[15:3] == 0) begin
      if (k == 2'd1 || k == 2'd2) begin e.fault = 1; e.vec = 10; end
      else begin e.ok = 1; e.acc = 17'h10000; end
    end else begin
      e.rd = 1;
      if (pfr) e.pf = 1;
      else begin
        t = d[44:40]; dpl = d[46:45]; rpl = s[1:0];
        case (k)
          2'd0: tok = (t == 5'h02);
          2'd1: tok = (t[4:3] == 2'b11);
          2'd2: tok = (t[4:3] == 2'b10) && t[1];
          default: tok = (t[4:3] == 2'b10) || (t[4:3] == 2'b11 && t[1]);
        endcase
        case (k)
          2'd2: bad = (rpl != c) || (dpl != c);
          2'd1: bad = t[2] ? (c < dpl) : (c != dpl);
          2'd3: bad = !(t[4:3] == 2'b11 && t[2]) && (rpl > dpl || c > dpl);
          default: bad = 0;
        endcase
        if (!tok) begin e.fault = 1; e.vec = 10; end
        else if (!d[47]) begin e.fault = 1; e.vec = (k == 2'd0) ? 8'd10 : (k == 2'd2) ? 8'd12 : 8'd11; end
        else if (bad) begin e.fault = 1; e.vec = 10; end
        else begin
          e.ok = 1;
          e.base = {d[63:56], d[39:16]};
          e.limit = d[55] ? {d[51:48], d[15:0], 12'hFFF} : {12'd0, d[51:48], d[15:0]};
          e.acc = {1'b0, d[55], d[54], d[53], d[52], 4'd0, d[47], dpl, t};
        end
      end
    end
    return e;
  endfunction

  task automatic run(input string tag, input logic [1:0] k, input logic [15:0] s, input logic [1:0] c,
                     input logic x, input logic [63:0] d, input logic pfr, input int lat);
    exp_t e;
    e = model(tag, k, s, c, x, d, pfr);
    exp_q.push_back(e);
    @(negedge clk);
    kind_i = k; sel_i = s; cpl_i = c; ext_i = x; start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (e.rd) begin
      chk(rd_req_o == 1, {tag, " R5 req"}, rd_req_o, 1);
      chk(rd_off_o == (s & 16'hFFF8) && rd_ldt_o == s[2], {tag, " R5 off"}, {rd_ldt_o, rd_off_o}, {s[2], s & 16'hFFF8});
      for (int i = 0; i < lat; i++) begin
        @(negedge clk);
        chk(rd_req_o == 1 && done_o == 0, {tag, " R5 hold"}, {rd_req_o, done_o}, 2'b10);
      end
      rd_data_i = d;
      if (pfr) begin rd_pf_i = 1; rd_valid_i = 1; end else rd_valid_i = 1;
      @(negedge clk);
      rd_valid_i = 0; rd_pf_i = 0;
      chk(rd_req_o == 0, {tag, " R5 drop"}, rd_req_o, 0);
    end else begin
      chk(rd_req_o == 0, {tag, " R4 no read"}, rd_req_o, 0);
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (exp_q.size() == 0) chk(0, "R13 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({ok_o, fault_o, pf_o} == {e.ok, e.fault, e.pf}, {e.tag, " outcome"}, {ok_o, fault_o, pf_o}, {e.ok, e.fault, e.pf});
        if (e.fault) chk(vec_o == e.vec && err_o == e.err, {e.tag, " vec/err R11"}, {vec_o, err_o}, {e.vec, e.err});
        if (e.ok) chk(base_o == e.base && limit_o == e.limit && access_o == e.acc, {e.tag, " decode R12"},
                      {limit_o, access_o[15:0]}, {e.limit, e.acc[15:0]});
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({done_o, rd_req_o, busy_o, ok_o, fault_o, pf_o} == 6'd0, "R1 reset", {done_o, rd_req_o, busy_o, ok_o, fault_o, pf_o}, 0);
    // R2 / R11
    run("R2 ldtr ti", 2'd0, 16'h0014, 2'd0, 1'b0, 64'd0, 0, 0);
    run("R2 R11 ldtr ti ext", 2'd0, 16'h0017, 2'd0, 1'b1, 64'd0, 0, 0);
    // R3
    run("R3 gdt over", 2'd1, 16'h0100, 2'd0, 1'b0, 64'd0, 0, 0);
    run("R3 gdt edge", 2'd3, 16'h00F8, 2'd0, 1'b0, mkdesc(32'h1000, 20'h10, 5'h13, 2'd0, 1, 0), 0, 1);
    run("R3 ldt over", 2'd3, 16'h0084, 2'd0, 1'b1, 64'd0, 0, 0);
    ldt_ok_i = 0;
    run("R3 ldt unusable", 2'd3, 16'h000F, 2'd0, 1'b1, 64'd0, 0, 0);
    ldt_ok_i = 1;
    // R4
    run("R4 null data", 2'd3, 16'h0003, 2'd0, 1'b0, 64'd0, 0, 0);
    run("R4 null ldtr", 2'd0, 16'h0000, 2'd0, 1'b0, 64'd0, 0, 0);
    run("R4 null ss", 2'd2, 16'h0000, 2'd0, 1'b1, 64'd0, 0, 0);
    run("R4 null cs", 2'd1, 16'h0002, 2'd0, 1'b0, 64'd0, 0, 0);
    // R12 / R9 good code
    run("R12 code gran", 2'd1, 16'h0008, 2'd0, 1'b0, mkdesc(32'h12345678, 20'hFFFFF, 5'h1B, 2'd0, 1, 1), 0, 3);
    run("R12 data byte", 2'd3, 16'h0013, 2'd0, 1'b0, mkdesc(32'hA0B0C0D0, 20'h54321, 5'h13, 2'd3, 1, 0), 0, 0);
    run("R6 ldt ok", 2'd0, 16'h0020, 2'd0, 1'b0, mkdesc(32'h8000, 20'h3F, 5'h02, 2'd0, 1, 0), 0, 2);
    // R6
    run("R6 ss code type", 2'd2, 16'h0010, 2'd0, 1'b0, mkdesc(0, 20'h1, 5'h1B, 2'd0, 1, 0), 0, 0);
    run("R6 ss readonly", 2'd2, 16'h0010, 2'd0, 1'b0, mkdesc(0, 20'h1, 5'h11, 2'd0, 1, 0), 0, 0);
    run("R6 data exec-only", 2'd3, 16'h0018, 2'd0, 1'b0, mkdesc(0, 20'h1, 5'h18, 2'd0, 1, 0), 0, 0);
    run("R6 ldtr not ldt", 2'd0, 16'h0020, 2'd0, 1'b0, mkdesc(0, 20'h1, 5'h13, 2'd0, 1, 0), 0, 0);
    // R7
    run("R7 ss absent", 2'd2, 16'h0010, 2'd0, 1'b0, mkdesc(0, 20'h1, 5'h13, 2'd0, 0, 0), 0, 0);
    run("R7 data absent", 2'd3, 16'h0018, 2'd0, 1'b1, mkdesc(0, 20'h1, 5'h13, 2'd0, 0, 0), 0, 0);
    run("R7 ldtr absent", 2'd0, 16'h0020, 2'd0, 1'b0, mkdesc(0, 20'h1, 5'h02, 2'd0, 0, 0), 0, 0);
    run("R7 cs absent", 2'd1, 16'h0008, 2'd0, 1'b0, mkdesc(0, 20'h1, 5'h1B, 2'd0, 0, 0), 0, 0);
    // R8
    run("R8 ss rpl", 2'd2, 16'h0010, 2'd3, 1'b0, mkdesc(0, 20'h1, 5'h13, 2'd3, 1, 0), 0, 0);
    run("R8 ss dpl", 2'd2, 16'h0013, 2'd3, 1'b0, mkdesc(0, 20'h1, 5'h13, 2'd2, 1, 0), 0, 0);
    run("R8 ss good", 2'd2, 16'h0013, 2'd3, 1'b0, mkdesc(32'h4000, 20'h1, 5'h13, 2'd3, 1, 0), 0, 1);
    // R9
    run("R9 conf ok", 2'd1, 16'h000B, 2'd3, 1'b0, mkdesc(0, 20'h1, 5'h1F, 2'd0, 1, 0), 0, 0);
    run("R9 conf bad", 2'd1, 16'h0008, 2'd0, 1'b0, mkdesc(0, 20'h1, 5'h1F, 2'd3, 1, 0), 0, 0);
    run("R9 nonconf bad", 2'd1, 16'h000A, 2'd2, 1'b0, mkdesc(0, 20'h1, 5'h1B, 2'd1, 1, 0), 0, 0);
    // R10
    run("R10 data rpl", 2'd3, 16'h001B, 2'd0, 1'b0, mkdesc(0, 20'h1, 5'h13, 2'd0, 1, 0), 0, 0);
    run("R10 data cpl", 2'd3, 16'h0018, 2'd2, 1'b0, mkdesc(0, 20'h1, 5'h13, 2'd1, 1, 0), 0, 0);
    run("R10 conf code data", 2'd3, 16'h001B, 2'd3, 1'b0, mkdesc(0, 20'h1, 5'h1E, 2'd0, 1, 0), 0, 0);
    // R13
    run("R13 page fault", 2'd1, 16'h0008, 2'd0, 1'b0, 64'd0, 1, 2);
    finished = 1;
    chk(exp_q.size() == 0, "R13 pending results", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule